// File: doc/BRIEF.md
# Periodic SPI Burst Sequencer

This block runs repeated SPI bursts without a processor in the loop. It holds a table of transmit word slots and a matching table of receive word slots. A flat enable mask picks which slots take part in a burst. A burst starts when the programmable period timer expires or, in external-trigger mode, on a rising edge of the trigger input. Once started, the sequencer visits the enabled slots from the lowest index upward. For each slot it hands the transmit word to an external shift engine through a request/done handshake, and it writes the returned word into the receive slot with the same index. When the last enabled slot has been served, it raises a sticky data-available flag.

The enable mask is built from `NUM_MASKS` words of `MASK_W` bits each. Bit r of word i enables slot i*MASK_W+r. The mask is captured when a burst starts, so software can prepare the next mask while a burst is running. When automatic select is enabled, the active-low slave-select output carries the burst select pattern during a burst and the idle pattern between bursts. While automatic operation is armed or a burst is running, the block reports that the ordinary software-fed transfer path must stay unused.

Top module: `spi_auto_seq`

## Requirements
- R1: After reset, `busy_o`, `ne_o` and `xfer_req_o` are 0, `fifo_ok_o` is 1, and `slvsel_o` equals `idle_sel_i`.
- R2: With `eact_i`=1, each rising edge of `ext_trig_i` seen while idle starts a burst, and the period timer starts no burst. `eact_i` takes precedence over `act_i`.
- R3: With `act_i`=1 and `eact_i`=0, bursts start every `period_i`+1 clock cycles, counted from one start to the next.
- R4: Bit i*MASK_W+r of `mask_i` enables slot i*MASK_W+r. `mask_i` is sampled when the burst starts. Enabled slots are served in strictly increasing index order, and slot NUM_SLOTS-1 is the last slot that can be served.
- R5: For each enabled slot there is exactly one transfer. `xfer_req_o` stays high, and `xfer_data_o` holds that slot's transmit word unchanged, until `xfer_done_i` is seen.
- R6: The `xfer_rdata_i` value present with `xfer_done_i` is written to the receive slot of the same index, which can be read on `rx_data_o` at `rx_addr_i`. Receive slots that are not enabled keep their contents.
- R7: `ne_o` becomes 1 when a burst completes and holds until `ne_clr_i`. A burst with an all-zero mask completes after exactly 2 busy cycles and makes no transfer request.
- R8: A trigger that arrives while `busy_o`=1 is ignored and is not queued.
- R9: With `act_i`=0 and `eact_i`=0, no new burst starts. A burst that is already running still completes.
- R10: With `asel_en_i`=1, `slvsel_o` equals `auto_sel_i` while `busy_o`=1 and equals `idle_sel_i` otherwise. With `asel_en_i`=0, `slvsel_o` always equals `idle_sel_i`. Select lines are active low, and all ones deselects every device.
- R11: `fifo_ok_o` is 0 whenever `act_i`, `eact_i` or `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Run bursts from the period timer |
| eact_i | input | 1 | Run bursts from the external trigger |
| period_i | input | PERIOD_W | Timer interval minus one, in cycles |
| ext_trig_i | input | 1 | External trigger; the rising edge counts |
| mask_i | input | NUM_MASKS*MASK_W | Slot enable bits |
| asel_en_i | input | 1 | Enable automatic slave select |
| idle_sel_i | input | SS_W | Select pattern used outside bursts |
| auto_sel_i | input | SS_W | Select pattern used during bursts |
| tx_we_i | input | 1 | Transmit slot write strobe |
| tx_addr_i | input | IDX_W | Transmit slot write index |
| tx_data_i | input | WORD_W | Transmit slot write data |
| rx_addr_i | input | IDX_W | Receive slot read index |
| rx_data_o | output | WORD_W | Receive slot read data |
| xfer_req_o | output | 1 | Word transfer request to the shift engine |
| xfer_data_o | output | WORD_W | Word to shift out |
| xfer_done_i | input | 1 | Shift engine finished the word |
| xfer_rdata_i | input | WORD_W | Word shifted in |
| slvsel_o | output | SS_W | Active-low slave selects |
| busy_o | output | 1 | Burst in progress |
| ne_o | output | 1 | Burst receive data available |
| ne_clr_i | input | 1 | Clear `ne_o` |
| fifo_ok_o | output | 1 | Software-fed transfer path may be used |

## Verification
The bench builds the block with two 8-bit mask words, which gives 16 slots, together with 16-bit words, an 8-bit period and 4 select lines. This size makes it cheap to run a mask that crosses the boundary between mask words, a mask with every slot set, and a burst that ends on the last slot. The small period lets several timer intervals be measured, and stopping can be tested in the middle of a burst. The latency of the shift engine model is adjustable, so a burst can be stretched long enough for a second trigger to arrive while it is still running.

// File: rtl/spi_auto_seq_pkg.sv
package spi_auto_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/spi_auto_seq_trig.sv
module spi_auto_seq_trig #(
  parameter int PERIOD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                act_i,
  input  logic                eact_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                ext_trig_i,
  output logic                trig_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                ext_q;
  logic                run_tmr;
  logic                tick;

  assign run_tmr = act_i & ~eact_i;
  assign tick    = run_tmr && (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_trig_i;
      if (!run_tmr || tick) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign trig_o = eact_i ? (ext_trig_i & ~ext_q) : tick;
endmodule

// File: rtl/spi_auto_seq_scan.sv
module spi_auto_seq_scan #(
  parameter int NUM_SLOTS = 128,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] mask_i,
  input  logic [IDX_W-1:0]     start_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     slot_o
);
  // lowest enabled slot at or above start
  always_comb begin
    found_o = 1'b0;
    slot_o  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (mask_i[i] && (i >= int'(start_i))) begin
        found_o = 1'b1;
        slot_o  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/spi_auto_seq_ram.sv
module spi_auto_seq_ram #(
  parameter int NUM_SLOTS = 128,
  parameter int WORD_W    = 32,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              tx_we_i,
  input  logic [IDX_W-1:0]  tx_waddr_i,
  input  logic [WORD_W-1:0] tx_wdata_i,
  input  logic [IDX_W-1:0]  tx_raddr_i,
  output logic [WORD_W-1:0] tx_rdata_o,
  input  logic              rx_we_i,
  input  logic [IDX_W-1:0]  rx_waddr_i,
  input  logic [WORD_W-1:0] rx_wdata_i,
  input  logic [IDX_W-1:0]  rx_raddr_i,
  output logic [WORD_W-1:0] rx_rdata_o
);
  logic [WORD_W-1:0] tx_mem [NUM_SLOTS];
  logic [WORD_W-1:0] rx_mem [NUM_SLOTS];

  always_ff @(posedge clk_i) begin
    if (tx_we_i) tx_mem[tx_waddr_i] <= tx_wdata_i;
    if (rx_we_i) rx_mem[rx_waddr_i] <= rx_wdata_i;
  end

  assign tx_rdata_o = tx_mem[tx_raddr_i];
  assign rx_rdata_o = rx_mem[rx_raddr_i];
endmodule

// File: rtl/spi_auto_seq.sv
module spi_auto_seq
  import spi_auto_seq_pkg::*;
#(
  parameter int NUM_MASKS = 4,
  parameter int MASK_W    = 32,
  parameter int WORD_W    = 32,
  parameter int PERIOD_W  = 32,
  parameter int SS_W      = 8,
  localparam int NUM_SLOTS = NUM_MASKS * MASK_W,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 act_i,
  input  logic                 eact_i,
  input  logic [PERIOD_W-1:0]  period_i,
  input  logic                 ext_trig_i,
  input  logic [NUM_SLOTS-1:0] mask_i,
  input  logic                 asel_en_i,
  input  logic [SS_W-1:0]      idle_sel_i,
  input  logic [SS_W-1:0]      auto_sel_i,
  input  logic                 tx_we_i,
  input  logic [IDX_W-1:0]     tx_addr_i,
  input  logic [WORD_W-1:0]    tx_data_i,
  input  logic [IDX_W-1:0]     rx_addr_i,
  output logic [WORD_W-1:0]    rx_data_o,
  output logic                 xfer_req_o,
  output logic [WORD_W-1:0]    xfer_data_o,
  input  logic                 xfer_done_i,
  input  logic [WORD_W-1:0]    xfer_rdata_i,
  output logic [SS_W-1:0]      slvsel_o,
  output logic                 busy_o,
  output logic                 ne_o,
  input  logic                 ne_clr_i,
  output logic                 fifo_ok_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  seq_state_e          state_q;
  logic [NUM_SLOTS-1:0] mask_q;
  logic [IDX_W-1:0]    idx_q, cur_q;
  logic [WORD_W-1:0]   data_q;
  logic                ne_q;
  logic                trig;
  logic                found;
  logic [IDX_W-1:0]    slot;
  logic [WORD_W-1:0]   tx_rd;
  logic                rx_we;

  spi_auto_seq_trig #(.PERIOD_W(PERIOD_W)) u_trig (
    .clk_i, .rst_ni, .act_i, .eact_i, .period_i, .ext_trig_i,
    .trig_o(trig)
  );

  spi_auto_seq_scan #(.NUM_SLOTS(NUM_SLOTS)) u_scan (
    .mask_i(mask_q), .start_i(idx_q), .found_o(found), .slot_o(slot)
  );

  assign rx_we = (state_q == ST_WAIT) && xfer_done_i;

  spi_auto_seq_ram #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W)) u_ram (
    .clk_i,
    .tx_we_i, .tx_waddr_i(tx_addr_i), .tx_wdata_i(tx_data_i),
    .tx_raddr_i(slot), .tx_rdata_o(tx_rd),
    .rx_we_i(rx_we), .rx_waddr_i(cur_q), .rx_wdata_i(xfer_rdata_i),
    .rx_raddr_i(rx_addr_i), .rx_rdata_o(rx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      idx_q   <= '0;
      cur_q   <= '0;
      data_q  <= '0;
      ne_q    <= 1'b0;
    end else begin
      if (state_q == ST_FIN) ne_q <= 1'b1;
      else if (ne_clr_i)     ne_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (trig) begin   // triggers while busy never reach here
          mask_q  <= mask_i;
          idx_q   <= '0;
          state_q <= ST_SCAN;
        end
        ST_SCAN: if (found) begin
          cur_q   <= slot;
          data_q  <= tx_rd;
          state_q <= ST_WAIT;
        end else begin
          state_q <= ST_FIN;
        end
        ST_WAIT: if (xfer_done_i) begin
          if (cur_q == LAST) state_q <= ST_FIN;
          else begin
            idx_q   <= cur_q + 1'b1;
            state_q <= ST_SCAN;
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign xfer_req_o  = (state_q == ST_WAIT);
  assign xfer_data_o = data_q;
  assign ne_o        = ne_q;
  assign slvsel_o    = (asel_en_i && busy_o) ? auto_sel_i : idle_sel_i;
  assign fifo_ok_o   = ~(act_i | eact_i | busy_o);
endmodule

// File: rtl/spi_auto_seq_chk.sv
module spi_auto_seq_chk #(
  parameter int WORD_W = 32,
  parameter int SS_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_req_o,
  input logic              xfer_done_i,
  input logic [WORD_W-1:0] xfer_data_o,
  input logic              busy_o,
  input logic              ne_o,
  input logic              ne_clr_i,
  input logic [SS_W-1:0]   slvsel_o,
  input logic [SS_W-1:0]   idle_sel_i,
  input logic [SS_W-1:0]   auto_sel_i,
  input logic              asel_en_i,
  input logic              fifo_ok_o
);
  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_done_i |=> xfer_req_o);
  a_r5_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_done_i |=> $stable(xfer_data_o));
  a_r5_req_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> busy_o);
  a_r7_ne_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ne_o && !ne_clr_i |=> ne_o);
  a_r7_ne_after_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ne_o) |-> $past(busy_o) && !busy_o);
  a_r10_ss_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && asel_en_i |-> slvsel_o == auto_sel_i);
  a_r10_ss_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && asel_en_i) |-> slvsel_o == idle_sel_i);
  a_r11_fifo_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !fifo_ok_o);
endmodule

bind spi_auto_seq spi_auto_seq_chk #(.WORD_W(WORD_W), .SS_W(SS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .xfer_req_o(xfer_req_o),
  .xfer_done_i(xfer_done_i), .xfer_data_o(xfer_data_o), .busy_o(busy_o),
  .ne_o(ne_o), .ne_clr_i(ne_clr_i), .slvsel_o(slvsel_o),
  .idle_sel_i(idle_sel_i), .auto_sel_i(auto_sel_i), .asel_en_i(asel_en_i),
  .fifo_ok_o(fifo_ok_o)
);

// File: tb/spi_auto_seq_tb_top.sv
module spi_auto_seq_tb_top;
  localparam int NM = 2, MW = 8, WW = 16, PW = 8, SW = 4;
  localparam int NS = NM * MW;
  localparam int IW = $clog2(NS);
  localparam logic [WW-1:0] XK = 16'h5A3C;
  localparam logic [SW-1:0] IDLE_SS = 4'hF;
  localparam logic [SW-1:0] AUTO_SS = ~(4'b1 << (2 - 1));

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic act_i = 0, eact_i = 0, ext_trig_i = 0, asel_en_i = 0;
  logic [PW-1:0] period_i = '0;
  logic [NS-1:0] mask_i = '0;
  logic [SW-1:0] idle_sel_i = IDLE_SS, auto_sel_i = AUTO_SS;
  logic tx_we_i = 0;
  logic [IW-1:0] tx_addr_i = '0, rx_addr_i = '0;
  logic [WW-1:0] tx_data_i = '0;
  logic [WW-1:0] rx_data_o, xfer_data_o;
  logic [WW-1:0] xfer_rdata_i = '0;
  logic xfer_req_o, xfer_done_i = 0;
  logic [SW-1:0] slvsel_o;
  logic busy_o, ne_o, fifo_ok_o, ne_clr_i = 0;

  always #2 clk_i = ~clk_i;

  spi_auto_seq #(.NUM_MASKS(NM), .MASK_W(MW), .WORD_W(WW), .PERIOD_W(PW), .SS_W(SW)) dut_i (.*);

  int checks = 0, errors = 0;
  int cyc = 0, rise_cnt = 0, req_cnt = 0, blen = 0, last_blen = 0, eng_cnt = 0, eng_lat = 1;
  int rise_t[$];
  logic [WW-1:0] exp_q[$];
  logic [WW-1:0] tx_model [NS];
  logic [WW-1:0] rx_exp [NS];
  logic busy_d = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // shift engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (busy_o && !busy_d) begin rise_cnt++; rise_t.push_back(cyc); blen = 0; end
      if (busy_o) blen++;
      if (!busy_o && busy_d) last_blen = blen;
      busy_d = busy_o;
      if (xfer_done_i) xfer_done_i = 1'b0;
      else if (xfer_req_o) begin
        if (eng_cnt == eng_lat) begin
          if (exp_q.size() == 0) chk(0, "R5 unexpected transfer", xfer_data_o, 0);
          else begin
            logic [WW-1:0] e;
            e = exp_q.pop_front();
            chk(xfer_data_o == e, "R4 slot order/data", xfer_data_o, e);
          end
          chk(slvsel_o == (asel_en_i ? auto_sel_i : idle_sel_i), "R10 select in burst",
              slvsel_o, asel_en_i ? auto_sel_i : idle_sel_i);
          xfer_rdata_i = xfer_data_o ^ XK;
          xfer_done_i  = 1'b1;
          eng_cnt = 0;
          req_cnt++;
        end else eng_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
  end

  task automatic write_tx(input int s, input logic [WW-1:0] v);
    @(negedge clk_i);
    tx_we_i = 1; tx_addr_i = IW'(s); tx_data_i = v;
    @(negedge clk_i);
    tx_we_i = 0;
    tx_model[s] = v;
  endtask

  task automatic expect_burst(input logic [NS-1:0] m);
    for (int s = 0; s < NS; s++)
      if (m[s]) begin exp_q.push_back(tx_model[s]); rx_exp[s] = tx_model[s] ^ XK; end
  endtask

  task automatic clear_ne();
    @(negedge clk_i); ne_clr_i = 1;
    @(negedge clk_i); ne_clr_i = 0;
  endtask

  task automatic pulse_ext();
    @(negedge clk_i); ext_trig_i = 1;
    @(negedge clk_i); ext_trig_i = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk_i); while (busy_o || !ne_o);
  endtask

  task automatic check_rx(input int s, input string tag);
    @(negedge clk_i); rx_addr_i = IW'(s);
    @(negedge clk_i);
    chk(rx_data_o == rx_exp[s], tag, rx_data_o, rx_exp[s]);
  endtask

  task automatic ext_burst(input logic [NS-1:0] m);
    clear_ne();
    mask_i = m;
    expect_burst(m);
    pulse_ext();
    mask_i = '0;  // sampled at start only
    wait_done();
  endtask

  initial begin
    int r0, q0;
    logic [WW-1:0] old3;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!busy_o && !ne_o && !xfer_req_o, "R1 reset flags", {busy_o, ne_o, xfer_req_o}, 0);
    chk(fifo_ok_o == 1, "R1 fifo_ok", fifo_ok_o, 1);
    chk(slvsel_o == IDLE_SS, "R1 select", slvsel_o, IDLE_SS);
    rst_ni = 1;
    for (int s = 0; s < NS; s++) write_tx(s, WW'(16'h1000 + s * 16'h0111));

    // R2 R4 R6 R10: boundary-crossing mask, external trigger wins over act
    asel_en_i = 1; eact_i = 1; act_i = 1; period_i = 8'd2;
    @(negedge clk_i);
    chk(fifo_ok_o == 0, "R11 fifo blocked when armed", fifo_ok_o, 0);
    repeat (12) @(negedge clk_i);
    chk(rise_cnt == 0, "R2 timer ignored under eact", rise_cnt, 0);
    act_i = 0;
    q0 = req_cnt;
    ext_burst(16'h8181);
    chk(req_cnt - q0 == 4, "R5 one transfer per slot", req_cnt - q0, 4);
    chk(exp_q.size() == 0, "R4 all slots served", exp_q.size(), 0);
    chk(ne_o == 1, "R7 ne set", ne_o, 1);
    chk(slvsel_o == IDLE_SS, "R10 idle select after burst", slvsel_o, IDLE_SS);
    check_rx(0, "R6 rx slot 0");
    check_rx(7, "R6 rx slot 7");
    check_rx(8, "R6 rx slot 8");
    check_rx(15, "R6 rx slot 15");
    repeat (3) @(negedge clk_i);
    chk(ne_o == 1, "R7 ne sticky", ne_o, 1);
    clear_ne();
    chk(ne_o == 0, "R7 ne cleared", ne_o, 0);

    // R6 disabled slot keeps contents
    ext_burst(16'h0008);
    old3 = rx_exp[3];
    write_tx(3, 16'hBEEF);
    write_tx(5, 16'hCAFE);
    ext_burst(16'h0020);
    check_rx(3, "R6 disabled slot kept");
    chk(rx_exp[3] == old3, "R6 model kept", rx_exp[3], old3);
    check_rx(5, "R6 rx slot 5");

    // R7 empty mask
    q0 = req_cnt;
    ext_burst('0);
    chk(req_cnt == q0, "R7 empty burst no request", req_cnt - q0, 0);
    chk(last_blen == 2, "R7 empty burst length", last_blen, 2);

    // R8 trigger during burst ignored
    eng_lat = 12;
    r0 = rise_cnt; q0 = req_cnt;
    clear_ne();
    mask_i = 16'h0008; expect_burst(16'h0008);
    pulse_ext();
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1, "R8 burst running", busy_o, 1);
    pulse_ext();
    wait_done();
    repeat (30) @(negedge clk_i);
    chk(rise_cnt - r0 == 1, "R8 no queued burst", rise_cnt - r0, 1);
    chk(req_cnt - q0 == 1, "R8 single transfer", req_cnt - q0, 1);

    // R4 full mask, last slot, select disabled
    eng_lat = 0; asel_en_i = 0;
    ext_burst('1);
    chk(exp_q.size() == 0, "R4 full mask served", exp_q.size(), 0);
    check_rx(15, "R4 last slot stored");
    check_rx(6, "R6 rx slot 6");

    // R3 period and R9 stop mid burst
    eng_lat = 2; asel_en_i = 1; eact_i = 0;
    clear_ne();
    mask_i = 16'h0002;
    for (int k = 0; k < 8; k++) expect_burst(16'h0002);
    r0 = rise_cnt; q0 = req_cnt;
    @(negedge clk_i); period_i = 8'd9; act_i = 1;
    while (rise_cnt < r0 + 3) @(negedge clk_i);
    act_i = 0;
    chk(busy_o == 1, "R9 stop during burst", busy_o, 1);
    repeat (40) @(negedge clk_i);
    chk(rise_t[r0 + 1] - rise_t[r0] == 10, "R3 interval 1", rise_t[r0 + 1] - rise_t[r0], 10);
    chk(rise_t[r0 + 2] - rise_t[r0 + 1] == 10, "R3 interval 2", rise_t[r0 + 2] - rise_t[r0 + 1], 10);
    chk(rise_cnt - r0 == 3, "R9 no burst after stop", rise_cnt - r0, 3);
    chk(req_cnt - q0 == 3, "R9 running burst completed", req_cnt - q0, 3);
    chk(ne_o == 1, "R9 ne after last burst", ne_o, 1);
    chk(fifo_ok_o == 1, "R11 fifo free when stopped", fifo_ok_o, 1);
    exp_q.delete();
    report();
  end
endmodule